// File: doc/BRIEF.md
# GPIO Pad Receive Event Unit

This block covers the receive side of one general-purpose pad. The raw pad level is brought into the system clock domain through a two-stage synchronizer. It can then be cleaned by a debounce filter, which counts pulses of a slow real-time tick. The filtered level may be inverted. An event detector then looks for a level, a single edge or either edge, as the trigger field selects. A qualifying event sets a sticky status bit, and software clears that bit with a one-cycle clear pulse. The status bit is forwarded through registered one-hot enables to four interrupt destinations: NMI, SMI, SCI and IOAPIC. More than one destination may be enabled at the same time.

Configuration arrives as two 32-bit words. The main word holds the buffer disables, the function select, routing, polarity and trigger. The filter word holds the debounce enable and length. The transmit path is reduced to its output-enable gating.

Top module: `gpio_rx_event_unit`

## Requirements
- R1: Reset is synchronous and active low. While it is held, and on the first cycle after it, `evt_sts`, `irq_out` and `rx_state` read 0. With the filter off and the receive buffer on, `rx_state` follows `pad_in` two clock cycles later.
- R2: The filter is on when `cfg_w2[0]` is 1. The filtered level takes the synchronized value only after that value has differed from it on every cycle across the full count of `rtc_tick` pulses. A return to the old level clears the count. The filtered level never changes on a cycle without a tick.
- R3: The filter length is 2^N tick pulses, where N is `cfg_w2[4:1]`. Codes 0, 1 and 2 act as code 3, so the shortest filter is 8 ticks.
- R4: The trigger field `cfg_w0[26:25]` selects the mode. Code 0 is level: status is set on every cycle in which the polarity-corrected level is 1.
- R5: Trigger code 1 is single edge. With the invert bit `cfg_w0[23]` at 0 a rising pad edge sets status. With it at 1 a falling pad edge sets status, because the inverted level rises.
- R6: Trigger code 3 sets status on both rising and falling edges of the polarity-corrected level.
- R7: Trigger code 2 never sets status.
- R8: When the receive-buffer disable `cfg_w0[9]` is 1, status is never set and `rx_state` reads 0.
- R9: When the function select `cfg_w0[12:10]` is nonzero, the pad serves a native function and status is never set. Only 0 selects GPIO operation.
- R10: A one-cycle `sts_clr` pulse clears status on the next cycle, unless an event occurs in the same cycle. In that case status stays 1, so in level mode it stays set while the level is high.
- R11: Each `irq_out[i]` equals the previous cycle's status ANDed with routing enable `cfg_w0[17+i]`. The enables map as follows: bit 0 NMI, bit 1 SMI, bit 2 SCI, bit 3 IOAPIC. Two enables may be set at once.
- R12: `tx_en` is the inverse of the transmit-buffer disable `cfg_w0[8]`. `tx_drive` is the transmit value `cfg_w0[0]` while enabled, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pad_in | input | 1 | Raw, asynchronous pad level |
| rtc_tick | input | 1 | One-cycle pulse per slow-clock period |
| cfg_w0 | input | 32 | Main pad configuration word |
| cfg_w2 | input | 32 | Debounce configuration word |
| sts_clr | input | 1 | Write-one-to-clear pulse for the status bit |
| rx_state | output | 1 | Synchronized, filtered receive level (0 when receive is disabled) |
| evt_sts | output | 1 | Sticky event status |
| irq_out | output | 4 | Registered interrupt outputs: NMI, SMI, SCI, IOAPIC |
| tx_en | output | 1 | Transmit buffer enable |
| tx_drive | output | 1 | Gated transmit value |

## Verification
The clear pulse and a fresh event can arrive in the same cycle, and the design must let the event win. The bench provokes this in level mode by pulsing `sts_clr` while the pad is held high. It then pulses the clear again once the pad has fallen, to confirm that the status drops. A second overlap comes from the filter: a glitch that returns on the same cycle a tick arrives must not update the filtered level. A behavioural model predicts status, routes and receive state on every cycle, and any divergence is reported against the requirement under test.

// File: rtl/gpio_evt_pkg.sv
// Package: shared field positions, trigger encoding and decoded
// configuration type for the pad receive event unit.
package gpio_evt_pkg;

    localparam int W0_TX_VAL   = 0;
    localparam int W0_TX_DIS   = 8;
    localparam int W0_RX_DIS   = 9;
    localparam int W0_MODE_LO  = 10;
    localparam int MODE_W      = 3;
    localparam int W0_ROUTE_LO = 17;
    localparam int NUM_ROUTES  = 4;
    localparam int W0_INV      = 23;
    localparam int W0_TRIG_LO  = 25;
    localparam int W2_FLT_EN   = 0;
    localparam int W2_CODE_LO  = 1;
    localparam int FLT_CODE_W  = 4;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_EDGE1 = 2'd1,
        TRIG_NONE  = 2'd2,
        TRIG_EDGE2 = 2'd3
    } trig_e;

    typedef struct packed {
        logic                  tx_val;
        logic                  tx_dis;
        logic                  rx_dis;
        logic [MODE_W-1:0]     func_sel;
        logic [NUM_ROUTES-1:0] route_en;
        logic                  inv;
        trig_e                 trig;
    } pad_cfg_t;

    // Pull the fields the receive path uses out of the main word.
    function automatic pad_cfg_t decode_w0(input logic [31:0] w);
        pad_cfg_t c;
        c.tx_val   = w[W0_TX_VAL];
        c.tx_dis   = w[W0_TX_DIS];
        c.rx_dis   = w[W0_RX_DIS];
        c.func_sel = w[W0_MODE_LO +: MODE_W];
        c.route_en = w[W0_ROUTE_LO +: NUM_ROUTES];
        c.inv      = w[W0_INV];
        c.trig     = trig_e'(w[W0_TRIG_LO +: 2]);
        return c;
    endfunction

endpackage

// File: rtl/pad_rx_sync.sv
// Module: pad_rx_sync
// Moves the asynchronous pad level into the clk domain through a
// flop chain. Assumes STAGES >= 2; output lags input by STAGES cycles.
module pad_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the pad level one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/pad_debounce.sv
// Module: pad_debounce
// Holds a filtered copy of the synchronized level. The copy takes a new
// value only after the input has differed from it for 2^code tick
// pulses in a row. Codes below MIN_CODE are raised to MIN_CODE. When
// disabled, the copy tracks the input so re-enabling starts clean.
module pad_debounce #(
    parameter int CODE_W   = 4,
    parameter int MIN_CODE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic              tick,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    output logic              dout
);
    localparam int MAX_CODE = (1 << CODE_W) - 1;
    localparam int CNT_W    = (MAX_CODE < 1) ? 1 : MAX_CODE;

    logic [CODE_W-1:0] eff_code;
    logic [CNT_W:0]    span;
    logic [CNT_W-1:0]  last_cnt;
    logic [CNT_W-1:0]  cnt;
    logic              held;

    // Clamp the length code to the shortest legal filter.
    always_comb begin
        eff_code = (code < CODE_W'(MIN_CODE)) ? CODE_W'(MIN_CODE) : code;
        span     = {{CNT_W{1'b0}}, 1'b1} << eff_code;
        last_cnt = span[CNT_W-1:0] - {{(CNT_W-1){1'b0}}, 1'b1};
    end

    // Count ticks while the input differs; commit after the full window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
            cnt  <= '0;
        end else if (!en) begin
            held <= din;
            cnt  <= '0;
        end else if (din == held) begin
            cnt  <= '0;
        end else if (tick) begin
            if (cnt == last_cnt) begin
                held <= din;
                cnt  <= '0;
            end else begin
                cnt  <= cnt + 1'b1;
            end
        end
    end

    assign dout = held;

    // R2: with the filter running, the level only moves on a tick.
    p_change_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && (held != $past(held))) |-> $past(tick));

    // R2: an input that matched the filtered level cannot move it.
    p_hold_when_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (din == held)) |=> $stable(held));
endmodule

// File: rtl/pad_event_detect.sv
// Module: pad_event_detect
// Applies polarity, then flags a level, single-edge or dual-edge event
// per the trigger code. Events are suppressed when receive is disabled,
// when a native function is selected or when the trigger is off.
module pad_event_detect
    import gpio_evt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  filt,
    input  logic  inv,
    input  trig_e trig,
    input  logic  rx_dis,
    input  logic  gpio_mode,
    output logic  evt
);
    logic pol;
    logic pol_q;
    logic hit;

    assign pol = filt ^ inv;

    // Remember last cycle's corrected level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pol_q <= 1'b0;
        else        pol_q <= pol;
    end

    // Select the event condition for the trigger code.
    always_comb begin
        case (trig)
            TRIG_LEVEL: hit = pol;
            TRIG_EDGE1: hit = pol & ~pol_q;
            TRIG_EDGE2: hit = pol ^ pol_q;
            default:    hit = 1'b0;
        endcase
    end

    assign evt = hit & ~rx_dis & gpio_mode;

    // R7: the off code never produces an event.
    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_NONE) |-> !evt);

    // R8: a disabled receive buffer never produces an event.
    p_rxdis_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dis |-> !evt);

    // R9: native functions bypass the event logic.
    p_native_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !gpio_mode |-> !evt);

    // R4: in level mode a high corrected level held over two cycles keeps firing.
    p_level_fires_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_LEVEL && gpio_mode && !rx_dis && pol && pol_q) |-> evt);
endmodule

// File: rtl/pad_status_route.sv
// Module: pad_status_route
// Sticky status bit with write-one-to-clear. An event in the same
// cycle as a clear wins. Registered per-destination outputs gate the
// status with each one-hot routing enable.
module pad_status_route #(
    parameter int N_ROUTES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt,
    input  logic                clr,
    input  logic [N_ROUTES-1:0] route_en,
    output logic                sts,
    output logic [N_ROUTES-1:0] irq
);
    // Set on event, drop on clear pulse, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) sts <= 1'b0;
        else        sts <= evt | (sts & ~clr);
    end

    // One registered, glitch-free output per destination.
    for (genvar i = 0; i < N_ROUTES; i++) begin : g_route
        always_ff @(posedge clk) begin
            if (!rst_n) irq[i] <= 1'b0;
            else        irq[i] <= sts & route_en[i];
        end
    end

    // R10: an event sets status on the next cycle, even during a clear.
    p_event_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> sts);

    // R10: a clear without a concurrent event drops status.
    p_clear_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !sts);

    // R11: no destination fires while status was low.
    p_route_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sts |=> (irq == '0));
endmodule

// File: rtl/gpio_rx_event_unit.sv
// Module: gpio_rx_event_unit (top)
// Receive-side event unit for one GPIO pad: synchronizer, optional
// debounce, polarity and trigger detection, sticky status and
// interrupt routing, plus transmit enable gating. Assumes rtc_tick is
// a single-cycle pulse in the clk domain.
module gpio_rx_event_unit
    import gpio_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_CODE    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pad_in,
    input  logic                  rtc_tick,
    input  logic [31:0]           cfg_w0,
    input  logic [31:0]           cfg_w2,
    input  logic                  sts_clr,
    output logic                  rx_state,
    output logic                  evt_sts,
    output logic [NUM_ROUTES-1:0] irq_out,
    output logic                  tx_en,
    output logic                  tx_drive
);
    pad_cfg_t              cfg;
    logic                  flt_en;
    logic [FLT_CODE_W-1:0] flt_code;
    logic                  sync_lvl;
    logic                  deb_lvl;
    logic                  filt;
    logic                  evt;
    logic                  unused_cfg_bits;

    assign cfg      = decode_w0(cfg_w0);
    assign flt_en   = cfg_w2[W2_FLT_EN];
    assign flt_code = cfg_w2[W2_CODE_LO +: FLT_CODE_W];
    assign unused_cfg_bits = ^{cfg_w0[31:27], cfg_w0[24], cfg_w0[22:21],
                               cfg_w0[16:13], cfg_w0[7:1], cfg_w2[31:5]};

    pad_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (sync_lvl)
    );

    pad_debounce #(.CODE_W(FLT_CODE_W), .MIN_CODE(MIN_CODE)) u_deb (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sync_lvl),
        .tick  (rtc_tick),
        .en    (flt_en),
        .code  (flt_code),
        .dout  (deb_lvl)
    );

    assign filt = flt_en ? deb_lvl : sync_lvl;

    pad_event_detect u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .filt      (filt),
        .inv       (cfg.inv),
        .trig      (cfg.trig),
        .rx_dis    (cfg.rx_dis),
        .gpio_mode (cfg.func_sel == '0),
        .evt       (evt)
    );

    pad_status_route #(.N_ROUTES(NUM_ROUTES)) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .clr      (sts_clr),
        .route_en (cfg.route_en),
        .sts      (evt_sts),
        .irq      (irq_out)
    );

    assign rx_state = filt & ~cfg.rx_dis;
    assign tx_en    = ~cfg.tx_dis;
    assign tx_drive = cfg.tx_val & ~cfg.tx_dis;

    // R8: a disabled receive buffer reads back as 0.
    p_rx_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.rx_dis |-> !rx_state);
endmodule

// File: tb/sim_gpio_rx_event_unit.sv
module sim_gpio_rx_event_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pad_in = 1'b0;
    logic        rtc_tick = 1'b0;
    logic [31:0] cfg_w0 = '0;
    logic [31:0] cfg_w2 = '0;
    logic        sts_clr = 1'b0;
    logic        rx_state, evt_sts, tx_en, tx_drive;
    logic [3:0]  irq_out;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cycles   = 0;
    int    tick_div = 0;
    string cur_req  = "R1";
    bit    model_ok = 0;

    // behavioural reference state
    bit m_q[$];
    bit m_deb, m_polp, m_sts;
    int m_cnt;
    int m_irq;

    always #4 clk = ~clk;

    gpio_rx_event_unit u0 (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .rtc_tick(rtc_tick),
        .cfg_w0(cfg_w0), .cfg_w2(cfg_w2), .sts_clr(sts_clr),
        .rx_state(rx_state), .evt_sts(evt_sts), .irq_out(irq_out),
        .tx_en(tx_en), .tx_drive(tx_drive)
    );

    function automatic logic [31:0] mk0(int trig, bit inv, int route, int fsel,
                                        bit rxd, bit txd, bit txv);
        logic [31:0] w = '0;
        w[26:25] = trig[1:0];
        w[23]    = inv;
        w[20:17] = route[3:0];
        w[12:10] = fsel[2:0];
        w[9]     = rxd;
        w[8]     = txd;
        w[0]     = txv;
        return w;
    endfunction

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        bit s2, filt, pol, evt, fen;
        int trig, code, lim;
        model_ok = 1;
        if (!rst_n) begin
            m_q = '{1'b0, 1'b0};
            m_deb = 0; m_polp = 0; m_sts = 0; m_cnt = 0; m_irq = 0;
        end else begin
            s2   = m_q[0];
            fen  = cfg_w2[0];
            filt = fen ? m_deb : s2;
            pol  = filt ^ cfg_w0[23];
            trig = int'(cfg_w0[26:25]);
            evt  = 0;
            if (cfg_w0[12:10] == 0 && !cfg_w0[9]) begin
                if (trig == 0) evt = pol;
                else if (trig == 1) evt = pol && !m_polp;
                else if (trig == 3) evt = (pol != m_polp);
            end
            m_irq  = m_sts ? int'(cfg_w0[20:17]) : 0;
            m_sts  = evt || (m_sts && !sts_clr);
            m_polp = pol;
            if (!fen) begin
                m_deb = s2; m_cnt = 0;
            end else if (s2 == m_deb) begin
                m_cnt = 0;
            end else if (rtc_tick) begin
                code = int'(cfg_w2[4:1]);
                if (code < 3) code = 3;
                lim = 1 << code;
                if (m_cnt + 1 == lim) begin
                    m_deb = s2; m_cnt = 0;
                end else m_cnt++;
            end
            m_q.push_back(pad_in);
            m_q.delete(0);
        end
    end

    task automatic chk(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        bit exp_rx;
        if (!model_ok) return;
        exp_rx = (cfg_w2[0] ? m_deb : m_q[0]) && !cfg_w0[9];
        chk("rx_state", int'(rx_state), int'(exp_rx));
        chk("evt_sts",  int'(evt_sts),  int'(m_sts));
        chk("irq_out",  int'(irq_out),  m_irq);
        chk("tx_en",    int'(tx_en),    int'(!cfg_w0[8]));
        chk("tx_drive", int'(tx_drive), int'(cfg_w0[0] && !cfg_w0[8]));
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            tick_div = (tick_div + 1) % 4;
            rtc_tick = (tick_div == 0);
        end
    endtask

    task automatic clear_pulse();
        sts_clr = 1'b1;
        step(1);
        sts_clr = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fails++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then two-cycle latency of the synchronizer
        cur_req = "R1";
        step(4);
        rst_n = 1'b1;
        cfg_w0 = mk0(2, 0, 0, 0, 0, 0, 0);
        step(2);
        pad_in = 1; step(5);
        pad_in = 0; step(5);

        // R4: level mode routed to SCI
        cur_req = "R4";
        cfg_w0 = mk0(0, 0, 4'b0100, 0, 0, 0, 0);
        pad_in = 1; step(4);
        pad_in = 0; step(3);
        clear_pulse(); step(3);

        // R10: clear while level is active, then clear after it falls
        cur_req = "R10";
        pad_in = 1; step(4);
        clear_pulse(); step(2);
        pad_in = 0; step(3);
        clear_pulse(); step(3);

        // R5: single edge, rising then falling via invert
        cur_req = "R5";
        cfg_w0 = mk0(1, 0, 4'b1000, 0, 0, 0, 0);
        pad_in = 1; step(4);
        clear_pulse(); pad_in = 0; step(4);
        clear_pulse(); step(1);
        cfg_w0 = mk0(1, 1, 4'b1000, 0, 0, 0, 0);
        step(3); clear_pulse(); step(2);
        pad_in = 1; step(4);
        pad_in = 0; step(4);
        clear_pulse(); step(2);

        // R6: both edges
        cur_req = "R6";
        cfg_w0 = mk0(3, 0, 4'b0010, 0, 0, 0, 0);
        step(3); clear_pulse(); step(1);
        pad_in = 1; step(4); clear_pulse(); step(1);
        pad_in = 0; step(4); clear_pulse(); step(2);

        // R7: trigger off
        cur_req = "R7";
        cfg_w0 = mk0(2, 0, 4'b1111, 0, 0, 0, 0);
        pad_in = 1; step(4); pad_in = 0; step(4);

        // R8: receive disabled in level mode
        cur_req = "R8";
        cfg_w0 = mk0(0, 0, 4'b1111, 0, 1, 0, 0);
        pad_in = 1; step(5); pad_in = 0; step(3);
        cfg_w0 = mk0(0, 1, 4'b1111, 0, 1, 0, 0);
        step(4);

        // R9: native function selected
        cur_req = "R9";
        cfg_w0 = mk0(0, 0, 4'b1111, 3, 0, 0, 0);
        pad_in = 1; step(5); pad_in = 0; step(3);

        // R11: one event to two destinations (NMI and IOAPIC)
        cur_req = "R11";
        cfg_w0 = mk0(0, 0, 4'b1001, 0, 0, 0, 0);
        pad_in = 1; step(4); pad_in = 0; step(3);
        clear_pulse(); step(3);

        // R2: debounce code 3, glitch then steady level
        cur_req = "R2";
        cfg_w2 = 32'h0000_0007;
        step(2);
        pad_in = 1; step(2); pad_in = 0; step(20);
        pad_in = 1; step(6); pad_in = 0; step(2); pad_in = 1; step(60);
        pad_in = 0; step(60);
        clear_pulse(); step(2);

        // R3: clamped short code and a longer code
        cur_req = "R3";
        cfg_w2 = 32'h0000_0003;
        pad_in = 1; step(50); pad_in = 0; step(50);
        cfg_w2 = 32'h0000_0009;
        pad_in = 1; step(90); pad_in = 0; step(90);
        clear_pulse(); step(2);
        cfg_w2 = '0;

        // R12: transmit gating
        cur_req = "R12";
        cfg_w0 = mk0(2, 0, 0, 0, 0, 0, 1); step(2);
        cfg_w0 = mk0(2, 0, 0, 0, 0, 1, 1); step(2);
        cfg_w0 = mk0(2, 0, 0, 0, 0, 1, 0); step(2);
        cfg_w0 = mk0(2, 0, 0, 0, 0, 0, 0); step(2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule